// File: doc/BRIEF.md
# Segmented Scan Test Sequencer

This block runs launch-off-capture delay tests on a scan chain that is cut into up to four segments of nearly equal length, each segment having its own clock enable. A descriptor, sampled when `start` is pulsed, gives the number of segments in use, the set of segments that receive the launch edge and the set that receive the capture edge. The block owns the scan cells: each segment is a shift register that either shifts serially from the shared scan input or loads its functional input in parallel.

A test runs in a fixed order. The first pattern is shifted in one segment at a time while every other segment is held. Scan enable then drops for exactly two functional edges: the launch edge clocks only the launch set, so segments left out keep the loaded values and the second pattern is a mix of loaded and computed values; the capture edge clocks the capture set. Scan enable rises again and the response is shifted out one segment at a time, with the matching output select steering that segment's tail onto the single scan output. A one-cycle `done` marks the end. Clocking every active segment on launch gives the ordinary broadside test; clocking one gives the lowest switching activity.

Top module: `segscan_seq`

## Requirements
- R1: While `rst_n` is low and in the cycle after, all clock enables, `scan_en`, all output selects and `done` are 0 and every scan cell is 0.
- R2: The descriptor is sampled only when `start` is high while the block is idle; a `start` during a run is ignored, and no new run follows it.
- R3: Loading takes segments in ascending order 0, 1, ...; segment i is enabled alone with `scan_en` = 1 and no output select for exactly its length in cycles (BASE_LEN+1 for i < NLONG, else BASE_LEN). The first bit shifted in ends at the segment's highest cell.
- R4: A segment whose clock enable is low keeps its contents, including segments outside the active count throughout a whole test.
- R5: After the last load cycle, exactly two cycles follow with `scan_en` = 0 and no output select: the first enables the launch mask, the second the capture mask (each ANDed with the active segments).
- R6: On the launch edge, segments in the launch mask take their functional input; others hold the loaded pattern.
- R7: On the capture edge, segments in the capture mask take their functional input; others hold.
- R8: Unloading starts in the cycle after capture, in ascending segment order, with `scan_en` = 1 and the segment's select and clock enable one-hot; `scan_out` shows the segment's highest cell, so bits leave in load order.
- R9: At most one output select is active at any time, and none while `scan_en` is 0.
- R10: `done` is high for exactly the one cycle after the last unload shift, after which the block is idle.
- R11: `cfg_nseg_m1` encodes the active segment count minus one; segments at or above the count are never enabled, whatever their mask bits.
- R12: A launch mask covering every active segment enables all of them on the launch edge, giving a standard broadside test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test; descriptor sampled with it |
| cfg_nseg_m1 | input | $clog2(NSEG) | Active segment count minus one |
| cfg_launch_mask | input | NSEG | Segments clocked on the launch edge |
| cfg_capture_mask | input | NSEG | Segments clocked on the capture edge |
| scan_in | input | 1 | Shared serial input of all segments |
| func_d | input | TOTAL | Functional capture value per scan cell |
| seg_clk_en | output | NSEG | Per-segment clock enable |
| scan_en | output | 1 | Shift (1) or functional capture (0) |
| so_sel | output | NSEG | Per-segment scan-out select |
| scan_out | output | 1 | Tail of the selected segment, 0 when none |
| done | output | 1 | One-cycle end-of-test pulse |
| cell_q | output | TOTAL | Scan cell contents, fed to functional logic |

## Verification
The bench closes the loop through a small functional function of the cell contents, so a design that clocked a segment outside the launch set, or skipped one inside it, returns a second pattern and response that differ from the model. Segments of both lengths are loaded and unloaded, which catches a counter that used one length for all or an off-by-one per segment that would misalign every later bit. Masks naming segments beyond the active count, a single active segment, an empty launch set and a start pulse during unload are driven; an error there would show as a stray enable, a corrupted idle segment or a second unrequested run. A reset in the middle of loading must leave the block idle with cleared cells.

// File: rtl/segscan_pkg.sv
// Shared types and length helpers for the segmented scan sequencer.
// Assumes segments 0..nlong-1 are one cell longer than the others.
package segscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_LAUNCH, ST_CAPTURE, ST_UNLOAD, ST_DONE
    } seq_state_t;

    // Length in cells of segment idx.
    function automatic int seg_len(input int base, input int nlong, input int idx);
        return base + ((idx < nlong) ? 1 : 0);
    endfunction

    // Index of the lowest cell of segment idx in the flat cell vector.
    function automatic int seg_off(input int base, input int nlong, input int idx);
        return idx * base + ((idx < nlong) ? idx : nlong);
    endfunction

endpackage

// File: rtl/scan_segment.sv
// One scan segment: a shift register with a parallel functional load.
// Assumes LEN >= 2. Holds while en is low; shifts toward the top cell
// when se is high, loads pd when se is low.
module scan_segment #(
    parameter int LEN = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           se,
    input  logic           si,
    input  logic [LEN-1:0] pd,
    output logic [LEN-1:0] q,
    output logic           so
);

    // Cell update: reset, shift, functional load or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= se ? {q[LEN-2:0], si} : pd;
    end

    assign so = q[LEN-1];

    // R4
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

endmodule

// File: rtl/seg_sequencer.sv
// Test sequencer: load each active segment in turn, one launch edge,
// one capture edge, unload each active segment in turn, pulse done.
// Assumes NSEG >= 2 and BASE_LEN >= 2; descriptor taken only when idle.
module seg_sequencer
    import segscan_pkg::*;
#(
    parameter int NSEG     = 4,
    parameter int BASE_LEN = 5,
    parameter int NLONG    = 2,
    localparam int SEGW    = $clog2(NSEG),
    localparam int CNTW    = $clog2(BASE_LEN + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SEGW-1:0] cfg_nseg_m1,
    input  logic [NSEG-1:0] cfg_launch,
    input  logic [NSEG-1:0] cfg_capture,
    output logic [NSEG-1:0] seg_en,
    output logic            scan_en,
    output logic [NSEG-1:0] so_sel,
    output logic            done
);

    seq_state_t      state;
    logic [SEGW-1:0] seg_idx, last_seg;
    logic [CNTW-1:0] bit_cnt;
    logic [NSEG-1:0] launch_q, capture_q, act_q, cfg_act, onehot;
    logic            last_bit, seg_end;

    // Active-segment mask implied by the incoming descriptor.
    always_comb begin
        for (int i = 0; i < NSEG; i++)
            cfg_act[i] = (i <= int'(cfg_nseg_m1));
    end

    assign onehot   = NSEG'(1) << seg_idx;
    assign last_bit = (int'(bit_cnt) == seg_len(BASE_LEN, NLONG, int'(seg_idx)) - 1);
    assign seg_end  = (seg_idx == last_seg);

    // State, segment index and per-segment shift counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            seg_idx   <= '0;
            bit_cnt   <= '0;
            last_seg  <= '0;
            launch_q  <= '0;
            capture_q <= '0;
            act_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_LOAD;
                    seg_idx   <= '0;
                    bit_cnt   <= '0;
                    last_seg  <= (int'(cfg_nseg_m1) > NSEG - 1) ? SEGW'(NSEG - 1) : cfg_nseg_m1;
                    launch_q  <= cfg_launch & cfg_act;
                    capture_q <= cfg_capture & cfg_act;
                    act_q     <= cfg_act;
                end
                ST_LOAD, ST_UNLOAD: begin
                    if (last_bit) begin
                        bit_cnt <= '0;
                        if (seg_end) begin
                            seg_idx <= '0;
                            state   <= (state == ST_LOAD) ? ST_LAUNCH : ST_DONE;
                        end else begin
                            seg_idx <= seg_idx + 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_LAUNCH:  state <= ST_CAPTURE;
                ST_CAPTURE: state <= ST_UNLOAD;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the current state.
    always_comb begin
        seg_en  = '0;
        so_sel  = '0;
        scan_en = 1'b0;
        case (state)
            ST_LOAD:    begin seg_en = onehot; scan_en = 1'b1; end
            ST_LAUNCH:  seg_en = launch_q;
            ST_CAPTURE: seg_en = capture_q;
            ST_UNLOAD:  begin seg_en = onehot; so_sel = onehot; scan_en = 1'b1; end
            default:    ;
        endcase
    end

    assign done = (state == ST_DONE);

    // R9
    so_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(so_sel));
    // R9
    so_sel_shift_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|so_sel) |-> scan_en);
    // R3
    load_single_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && so_sel == '0) |-> $countones(seg_en) == 1);
    // R5
    launch_then_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAUNCH) |=> (state == ST_CAPTURE && !scan_en));
    // R8
    unload_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|so_sel) |-> $past(state) == ST_CAPTURE);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && seg_en == '0));
    // R11
    inactive_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en & ~act_q) == '0);

endmodule

// File: rtl/segscan_seq.sv
// Top: sequencer plus NSEG scan segments on a shared scan input, with
// the selected segment's tail steered to a single scan output.
// Assumes the sequencer keeps at most one select active.
module segscan_seq
    import segscan_pkg::*;
#(
    parameter int NSEG     = 4,
    parameter int BASE_LEN = 5,
    parameter int NLONG    = 2,
    localparam int SEGW    = $clog2(NSEG),
    localparam int TOTAL   = seg_off(BASE_LEN, NLONG, NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEGW-1:0]  cfg_nseg_m1,
    input  logic [NSEG-1:0]  cfg_launch_mask,
    input  logic [NSEG-1:0]  cfg_capture_mask,
    input  logic             scan_in,
    input  logic [TOTAL-1:0] func_d,
    output logic [NSEG-1:0]  seg_clk_en,
    output logic             scan_en,
    output logic [NSEG-1:0]  so_sel,
    output logic             scan_out,
    output logic             done,
    output logic [TOTAL-1:0] cell_q
);

    logic [NSEG-1:0] tails;

    seg_sequencer #(.NSEG(NSEG), .BASE_LEN(BASE_LEN), .NLONG(NLONG)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_nseg_m1 (cfg_nseg_m1),
        .cfg_launch  (cfg_launch_mask),
        .cfg_capture (cfg_capture_mask),
        .seg_en      (seg_clk_en),
        .scan_en     (scan_en),
        .so_sel      (so_sel),
        .done        (done)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam int L = seg_len(BASE_LEN, NLONG, g);
        localparam int O = seg_off(BASE_LEN, NLONG, g);
        scan_segment #(.LEN(L)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (seg_clk_en[g]),
            .se    (scan_en),
            .si    (scan_in),
            .pd    (func_d[O +: L]),
            .q     (cell_q[O +: L]),
            .so    (tails[g])
        );
    end

    // Shared output: only the selected segment drives it.
    assign scan_out = |(so_sel & tails);

endmodule

// File: tb/segscan_seq_test.sv
`timescale 1ns/1ps
module segscan_seq_test;
    localparam int NB = 5, NL = 2, NS = 4, T = 22;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, scan_in = 1'b0;
    logic [1:0] cfg_n = '0;
    logic [3:0] cfg_l = '0, cfg_c = '0;
    logic [T-1:0] func_d, cell_q, model;
    logic [3:0] seg_clk_en, so_sel;
    logic scan_en, scan_out, done;
    int n_chk = 0, n_fail = 0;

    // Stand-in combinational logic between scan cells.
    assign func_d = ~{cell_q[T-2:0], cell_q[T-1]};

    segscan_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .cfg_nseg_m1(cfg_n),
        .cfg_launch_mask(cfg_l), .cfg_capture_mask(cfg_c), .scan_in(scan_in),
        .func_d(func_d), .seg_clk_en(seg_clk_en), .scan_en(scan_en), .so_sel(so_sel),
        .scan_out(scan_out), .done(done), .cell_q(cell_q));

    always #2 clk = ~clk;

    // entry: [31:10] pattern, [9:6] capture mask, [5:2] launch mask, [1:0] count-1
    localparam logic [31:0] VEC [0:5] = '{
        {22'h2B5C13, 4'b1111, 4'b1111, 2'd3},
        {22'h0F0F3A, 4'b1111, 4'b0001, 2'd3},
        {22'h3C965A, 4'b0010, 4'b0100, 2'd3},
        {22'h155AA5, 4'b1111, 4'b1010, 2'd2},
        {22'h3FFFF0, 4'b1111, 4'b1110, 2'd0},
        {22'h1248E7, 4'b0001, 4'b0010, 2'd1}
    };

    function automatic int lenof(input int i); return NB + ((i < NL) ? 1 : 0); endfunction
    function automatic int offof(input int i); return i * NB + ((i < NL) ? i : NL); endfunction
    function automatic int segof(input int b);
        for (int i = NS - 1; i >= 0; i--) if (b >= offof(i)) return i;
        return 0;
    endfunction
    function automatic logic [T-1:0] fmodel(input logic [T-1:0] x);
        return ~{x[T-2:0], x[T-1]};
    endfunction
    function automatic logic [T-1:0] edge_apply(input logic [T-1:0] x, input logic [3:0] m);
        logic [T-1:0] f = fmodel(x);
        logic [T-1:0] r = x;
        for (int b = 0; b < T; b++) if (m[segof(b)]) r[b] = f[b];
        return r;
    endfunction

    task automatic chk(input bit c, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input int nm1, input logic [3:0] lm, input logic [3:0] cm,
                            input logic [T-1:0] pat, input bit poke);
        logic [T-1:0] exp, v2, rsp;
        logic [3:0] act = 4'((1 << (nm1 + 1)) - 1);
        bit ok;
        @(negedge clk);
        start = 1'b1; cfg_n = 2'(nm1); cfg_l = lm; cfg_c = cm;
        @(negedge clk);
        start = 1'b0; cfg_l = 4'hF; cfg_c = 4'h0;
        exp = model;
        for (int i = 0; i <= nm1; i++) begin
            ok = 1;
            for (int k = 0; k < lenof(i); k++) begin
                if (!(scan_en && seg_clk_en == 4'(1 << i) && so_sel == 4'h0)) ok = 0;
                scan_in = pat[offof(i) + lenof(i) - 1 - k];
                @(negedge clk);
            end
            chk(ok, "R3 load enables", 64'(seg_clk_en), 64'(1 << i));
            for (int b = 0; b < lenof(i); b++) exp[offof(i) + b] = pat[offof(i) + b];
        end
        chk(cell_q == exp, "R3/R4 loaded pattern", 64'(cell_q), 64'(exp));
        chk(!scan_en && so_sel == 0 && seg_clk_en == (lm & act), "R5 launch enables",
            64'(seg_clk_en), 64'(lm & act));
        if (nm1 < 3) chk((seg_clk_en & ~act) == 0, "R11 inactive launch", 64'(seg_clk_en), 64'(act));
        if (lm == 4'hF && nm1 == 3) chk(seg_clk_en == 4'hF, "R12 broadside launch", 64'(seg_clk_en), 64'hF);
        v2 = edge_apply(exp, lm & act);
        @(negedge clk);
        chk(cell_q == v2, "R6 launch result", 64'(cell_q), 64'(v2));
        chk(!scan_en && so_sel == 0 && seg_clk_en == (cm & act), "R5 capture enables",
            64'(seg_clk_en), 64'(cm & act));
        rsp = edge_apply(v2, cm & act);
        @(negedge clk);
        chk(cell_q == rsp, "R7 capture result", 64'(cell_q), 64'(rsp));
        exp = rsp;
        for (int i = 0; i <= nm1; i++) begin
            ok = 1;
            for (int k = 0; k < lenof(i); k++) begin
                if (!(scan_en && so_sel == 4'(1 << i) && seg_clk_en == 4'(1 << i)
                      && scan_out == rsp[offof(i) + lenof(i) - 1 - k])) ok = 0;
                scan_in = 1'b0;
                start = (poke && i == 0 && k == 1);
                cfg_n = 2'd0; cfg_l = 4'hF; cfg_c = 4'hF;
                @(negedge clk);
            end
            chk(ok, "R8 unload order/data", 64'(so_sel), 64'(1 << i));
            for (int b = 0; b < lenof(i); b++) exp[offof(i) + b] = 1'b0;
        end
        start = 1'b0;
        chk(done && seg_clk_en == 0 && so_sel == 0, "R10 done pulse", 64'(done), 64'h1);
        @(negedge clk);
        chk(!done, "R10 done single cycle", 64'(done), 64'h0);
        for (int j = 0; j < 3; j++) begin
            chk(seg_clk_en == 0 && !scan_en && so_sel == 0, poke ? "R2 start during run ignored" : "R10 idle after done",
                64'(seg_clk_en), 64'h0);
            @(negedge clk);
        end
        chk(cell_q == exp, "R4 held/unloaded cells", 64'(cell_q), 64'(exp));
        model = exp;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model = '0;
        repeat (3) @(negedge clk);
        chk(seg_clk_en == 0 && !scan_en && so_sel == 0 && !done, "R1 reset outputs", 64'(seg_clk_en), 64'h0);
        chk(cell_q == '0, "R1 reset cells", 64'(cell_q), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seg_clk_en == 0 && !scan_en && !done, "R1 idle after reset", 64'(seg_clk_en), 64'h0);
        for (int v = 0; v < 6; v++)
            run_case(int'(VEC[v][1:0]), VEC[v][5:2], VEC[v][9:6], T'(VEC[v][31:10]), v == 2);
        // reset in the middle of loading
        start = 1'b1; cfg_n = 2'd3; scan_in = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(seg_clk_en == 0 && !scan_en && so_sel == 0 && cell_q == '0, "R1 reset mid-load",
            64'(cell_q), 64'h0);
        @(negedge clk);
        chk(seg_clk_en == 0 && !scan_en, "R1 idle after mid-load reset", 64'(seg_clk_en), 64'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule